// File: doc/BRIEF.md
# Streaming CRC24 Attachment Unit

This block sits on a byte-wide packet stream and protects each code block with a 24-bit cyclic redundancy check. The CRC is computed eight bits per clock as payload bytes pass through. When the last payload byte has gone out, the block appends the three CRC bytes. The output length then equals the configured code block size K, counted in bytes. The CRC logic can be switched off for a block. In that case the block expects all K bytes from the source and forwards them unchanged.

Both edges of the block use a valid/ready handshake with start and end of packet flags. The mode, the polynomial choice and the block length are plain inputs. They are taken on the first accepted beat of a packet and held for the rest of it. Framing faults in the incoming packet are reported on the last output beat of that packet as a two-bit code.

Top module: `crc24_attach`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 while `out_ready` is 1.
- R2: With `crc_en` high on the first beat, exactly K-3 payload bytes are accepted. They appear on the output unchanged and in order, followed by exactly three CRC bytes. No further beat follows.
- R3: Polynomial select 0 uses 0x864CFB and 1 uses 0x800063. The register is zero at the start of each packet. The bits of each byte are fed in most significant bit first, and the CRC is emitted with bits 23:16 first, then 15:8, then 7:0.
- R4: With `crc_en` low on the first beat, K bytes are accepted and forwarded unchanged, with nothing appended.
- R5: `out_sop` is set on the first output beat of a packet only. `out_eop` is set on the third CRC byte in CRC mode and on the last payload byte in bypass mode.
- R6: Beats with `in_valid` low are skipped. The output sequence does not depend on where such gaps fall.
- R7: From the cycle after the last payload byte is accepted in CRC mode, `in_ready` stays 0 until the final CRC byte has been loaded onto the output.
- R8: While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values in the next cycle, and no byte is lost or repeated.
- R9: `out_err` is 00 on every beat except the end beat. On the end beat it reads 11 if `in_eop` arrived before the expected length was reached. It reads 10 if the length was reached without `in_eop`; the packet is closed in that case. Otherwise it reads 01 if the first beat lacked `in_sop`, else 00.
- R10: Changes of `crc_en`, `poly_sel` and `blk_len` after the first beat of a packet have no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 8 | Input payload byte |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_ready | output | 1 | Block accepts a beat this cycle |
| crc_en | input | 1 | 1: append CRC, 0: bypass |
| poly_sel | input | 1 | 0: polynomial 0x864CFB, 1: 0x800063 |
| blk_len | input | 16 | Code block size K in bytes |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_err | output | 2 | Framing error code on the end beat |
| out_ready | input | 1 | Downstream accepts a beat |

## Verification
Two functions can fall in the same cycle: acceptance of the last payload byte, and a downstream stall that freezes the output register while the CRC byte phase is about to begin. The bench provokes this by toggling `out_ready` at random while feeding packets with random input gaps. For each packet it checks the whole output byte sequence, the flags and the error code against a CRC and framing model of its own. It also checks that `in_ready` stays low through the CRC byte phase and that stalled outputs do not change.

// File: rtl/crc24_pkg.sv
// Shared constants and types for the CRC24 attachment unit.
// Assumes one byte per beat and a 24-bit check value.
package crc24_pkg;
    localparam int          CRC_W       = 24;
    localparam int          BYTE_W      = 8;
    localparam int          CRC_BYTES   = CRC_W / BYTE_W;
    localparam logic [23:0] POLY_24A    = 24'h864CFB;
    localparam logic [23:0] POLY_24B    = 24'h800063;

    // Framing error codes reported on the end beat of a packet
    typedef enum logic [1:0] {
        ERR_NONE      = 2'b00,
        ERR_NO_SOP    = 2'b01,
        ERR_NO_EOP    = 2'b10,
        ERR_EARLY_EOP = 2'b11
    } frame_err_t;

    // Packet phase of the control unit
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_BODY = 2'b01,
        PH_TAIL = 2'b10
    } phase_t;
endpackage

// File: rtl/crc24_engine.sv
// Byte-parallel CRC24 register: folds one byte per step, MSB first.
// Assumes the caller raises restart together with step on the first
// byte of a packet, which seeds the fold with zero.
module crc24_engine
    import crc24_pkg::*;
#(
    parameter logic [23:0] POLY_LO = POLY_24A,
    parameter logic [23:0] POLY_HI = POLY_24B,
    parameter int          DW      = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    input  logic              poly_sel,
    input  logic [DW-1:0]     data,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] chain [0:DW];

    // Pick the generator and the seed for this step
    always_comb begin
        poly     = poly_sel ? POLY_HI : POLY_LO;
        chain[0] = restart ? '0 : crc_q;
    end

    // One shift-and-reduce stage per input bit, most significant first
    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic fb;
        assign fb           = chain[b][CRC_W-1] ^ data[DW-1-b];
        assign chain[b + 1] = {chain[b][CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end

    // Hold the running remainder between accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= '0;
        else if (step)
            crc_q <= chain[DW];
    end

    assign crc = crc_q;
endmodule

// File: rtl/crc24_frame_ctrl.sv
// Packet framing control: counts payload bytes against the expected
// length, latches per-packet settings on the first beat, classifies
// framing faults and sequences the three CRC byte slots.
// Assumes blk_len is at least 4 in CRC mode and at least 1 in bypass.
module crc24_frame_ctrl
    import crc24_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             crc_en,
    input  logic             poly_sel,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             out_slot,
    output logic             in_ready,
    output logic             accept,
    output logic             first_beat,
    output logic             poly_eff,
    output logic             pay_eop,
    output frame_err_t       pay_err,
    output logic             tail_emit,
    output logic             tail_last,
    output logic [1:0]       tail_idx,
    output frame_err_t       tail_err
);
    localparam logic [LEN_W-1:0] TAIL_LEN  = LEN_W'(CRC_BYTES);
    localparam logic [1:0]       TAIL_LAST = 2'(CRC_BYTES - 1);

    phase_t           ph_q;
    logic             mode_q, poly_q, miss_q;
    logic [LEN_W-1:0] need_q, cnt_q;
    logic [1:0]       idx_q;
    frame_err_t       err_q;

    logic             mode_eff, miss_eff, reached, last_beat;
    logic [LEN_W-1:0] need_raw, need_eff, cnt_nx;
    frame_err_t       err_now;

    // Decode the beat at the input against the packet in progress
    always_comb begin
        first_beat = (ph_q == PH_IDLE);
        in_ready   = (ph_q != PH_TAIL) && out_slot;
        accept     = in_valid && in_ready;
        mode_eff   = first_beat ? crc_en   : mode_q;
        poly_eff   = first_beat ? poly_sel : poly_q;
        miss_eff   = first_beat ? !in_sop  : miss_q;
        need_raw   = crc_en ? (blk_len - TAIL_LEN) : blk_len;
        need_eff   = first_beat ? need_raw : need_q;
        cnt_nx     = first_beat ? LEN_W'(1) : cnt_q + LEN_W'(1);
        reached    = (cnt_nx >= need_eff);
        last_beat  = reached || in_eop;
        if (in_eop && !reached)
            err_now = ERR_EARLY_EOP;
        else if (reached && !in_eop)
            err_now = ERR_NO_EOP;
        else if (miss_eff)
            err_now = ERR_NO_SOP;
        else
            err_now = ERR_NONE;
        pay_eop   = accept && last_beat && !mode_eff;
        pay_err   = pay_eop ? err_now : ERR_NONE;
        tail_emit = (ph_q == PH_TAIL) && out_slot;
        tail_last = tail_emit && (idx_q == TAIL_LAST);
        tail_idx  = idx_q;
        tail_err  = tail_last ? err_q : ERR_NONE;
    end

    // Advance the packet phase and hold the per-packet settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            mode_q <= 1'b0;
            poly_q <= 1'b0;
            miss_q <= 1'b0;
            need_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            err_q  <= ERR_NONE;
        end else if (accept) begin
            cnt_q <= cnt_nx;
            if (first_beat) begin
                mode_q <= crc_en;
                poly_q <= poly_sel;
                need_q <= need_raw;
                miss_q <= !in_sop;
            end
            if (last_beat) begin
                err_q <= err_now;
                idx_q <= '0;
                ph_q  <= mode_eff ? PH_TAIL : PH_IDLE;
            end else begin
                ph_q <= PH_BODY;
            end
        end else if (tail_emit) begin
            idx_q <= idx_q + 2'd1;
            if (idx_q == TAIL_LAST)
                ph_q <= PH_IDLE;
        end
    end

    AST_BODY_BELOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_BODY) |-> (cnt_q < need_q));                              // R2
    AST_TAIL_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_beat && mode_eff) |=> !in_ready);                    // R7
    AST_TAIL_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_emit && idx_q != TAIL_LAST) |=> (ph_q == PH_TAIL));             // R2
endmodule

// File: rtl/crc24_out_stage.sv
// Single output register for the byte stream with valid/ready hold.
// Assumes load is only raised when slot is high.
module crc24_out_stage
    import crc24_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d,
    input  logic          sop,
    input  logic          eop,
    input  frame_err_t    err,
    input  logic          out_ready,
    output logic          slot,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop,
    output logic [1:0]    out_err
);
    logic          v_q, s_q, e_q;
    logic [DW-1:0] d_q;
    frame_err_t    r_q;

    // Register is free when empty or being drained this cycle
    assign slot = !v_q || out_ready;

    // Capture a new beat or drop the one just taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
            s_q <= 1'b0;
            e_q <= 1'b0;
            r_q <= ERR_NONE;
        end else if (load) begin
            v_q <= 1'b1;
            d_q <= d;
            s_q <= sop;
            e_q <= eop;
            r_q <= err;
        end else if (out_ready) begin
            v_q <= 1'b0;
        end
    end

    assign out_valid = v_q;
    assign out_data  = d_q;
    assign out_sop   = s_q;
    assign out_eop   = e_q;
    assign out_err   = r_q;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_sop) && $stable(out_eop) && $stable(out_err)));    // R8
    AST_ERR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |-> (out_err == 2'b00));                     // R9
endmodule

// File: rtl/crc24_attach.sv
// Top of the CRC24 attachment unit: payload bytes pass through the
// output register while the engine folds them; in CRC mode three
// remainder bytes follow, high byte first. Assumes synchronous
// active-low reset and one byte per beat.
module crc24_attach
    import crc24_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             in_ready,
    input  logic             crc_en,
    input  logic             poly_sel,
    input  logic [LEN_W-1:0] blk_len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic [1:0]       out_err,
    input  logic             out_ready
);
    logic             slot, accept, first_beat, poly_eff;
    logic             pay_eop, tail_emit, tail_last;
    logic [1:0]       tail_idx;
    frame_err_t       pay_err, tail_err, ld_err;
    logic [CRC_W-1:0] crc;
    logic [BYTE_W-1:0] crc_byte, ld_data;
    logic             ld, ld_sop, ld_eop;

    crc24_frame_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .crc_en     (crc_en),
        .poly_sel   (poly_sel),
        .blk_len    (blk_len),
        .out_slot   (slot),
        .in_ready   (in_ready),
        .accept     (accept),
        .first_beat (first_beat),
        .poly_eff   (poly_eff),
        .pay_eop    (pay_eop),
        .pay_err    (pay_err),
        .tail_emit  (tail_emit),
        .tail_last  (tail_last),
        .tail_idx   (tail_idx),
        .tail_err   (tail_err)
    );

    crc24_engine #(.DW(BYTE_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (accept),
        .restart  (first_beat),
        .poly_sel (poly_eff),
        .data     (in_data),
        .crc      (crc)
    );

    // Select the remainder byte for the current tail slot, high first
    always_comb begin
        case (tail_idx)
            2'd0:    crc_byte = crc[23:16];
            2'd1:    crc_byte = crc[15:8];
            default: crc_byte = crc[7:0];
        endcase
    end

    // Merge payload and tail beats into one load request
    always_comb begin
        ld      = accept || tail_emit;
        ld_data = tail_emit ? crc_byte : in_data;
        ld_sop  = accept && first_beat;
        ld_eop  = tail_emit ? tail_last : pay_eop;
        ld_err  = tail_emit ? tail_err : pay_err;
    end

    crc24_out_stage #(.DW(BYTE_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .d         (ld_data),
        .sop       (ld_sop),
        .eop       (ld_eop),
        .err       (ld_err),
        .out_ready (out_ready),
        .slot      (slot),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_err   (out_err)
    );

    AST_ONE_SOURCE_PER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && tail_emit));                                             // R7
    AST_SOP_NOT_ON_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        tail_emit |=> !out_sop);                                             // R5
endmodule

// File: tb/crc24_attach_test.sv
module crc24_attach_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid, in_sop, in_eop, crc_en, poly_sel, out_ready;
    logic [7:0]       in_data;
    logic [LEN_W-1:0] blk_len;
    logic             in_ready, out_valid, out_sop, out_eop;
    logic [7:0]       out_data;
    logic [1:0]       out_err;

    int checks = 0;
    int fails  = 0;

    logic [7:0] pl    [0:63];
    logic [7:0] exp_d [0:79];
    logic       exp_s [0:79];
    logic       exp_e [0:79];
    int         exp_r [0:79];
    int         exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc24_attach #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
        .crc_en(crc_en), .poly_sel(poly_sel), .blk_len(blk_len),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_err(out_err), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference remainder over the first n payload bytes (R3)
    function automatic logic [23:0] ref_crc(input int n, input bit pb);
        logic [23:0] r = 24'h0;
        logic [23:0] g = pb ? 24'h800063 : 24'h864CFB;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                logic top = r[23] ^ pl[i][b];
                r = {r[22:0], 1'b0} ^ (top ? g : 24'h0);
            end
        return r;
    endfunction

    task automatic run_pkt(input int k, input bit en, input bit pb, input int nsend,
                           input bit give_sop, input bit give_eop,
                           input bit gappy, input bit bp);
        int need = en ? k - 3 : k;
        int errc, sent = 0, got = 0, cyc = 0;
        bit in_tail = 0, prev_stall = 0;
        logic [7:0] pd = '0;
        logic pe = 0;
        logic [23:0] c;
        for (int i = 0; i < 64; i++) pl[i] = 8'($urandom);
        if (nsend < need)      errc = 3;
        else if (!give_eop)    errc = 2;
        else if (!give_sop)    errc = 1;
        else                   errc = 0;
        exp_n = 0;
        for (int i = 0; i < nsend; i++) begin
            exp_d[exp_n] = pl[i]; exp_s[exp_n] = (i == 0);
            exp_e[exp_n] = 0; exp_r[exp_n] = 0; exp_n++;
        end
        if (en) begin
            c = ref_crc(nsend, pb);
            for (int j = 0; j < 3; j++) begin
                exp_d[exp_n] = c[23 - 8*j -: 8]; exp_s[exp_n] = 0;
                exp_e[exp_n] = 0; exp_r[exp_n] = 0; exp_n++;
            end
        end
        exp_e[exp_n-1] = 1; exp_r[exp_n-1] = errc;
        while ((sent < nsend || got < exp_n) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (sent < nsend) begin
                in_valid = gappy ? ($urandom % 3 != 0) : 1'b1;
                in_data  = pl[sent];
                in_sop   = (sent == 0) && give_sop;
                in_eop   = give_eop && (sent == nsend - 1);
                if (sent == 0) begin
                    crc_en = en; poly_sel = pb; blk_len = LEN_W'(k);
                end else begin // R10: settings scrambled mid-packet
                    crc_en = 1'($urandom); poly_sel = 1'($urandom);
                    blk_len = LEN_W'($urandom % 50);
                end
            end else begin
                in_valid = 0; in_sop = 0; in_eop = 0;
            end
            out_ready = bp ? 1'($urandom) : 1'b1;
            #1;
            if (prev_stall) begin
                chk(out_valid && out_data == pd && out_eop == pe, "R8",
                    "stalled beat changed", int'(out_data), int'(pd));
            end
            if (out_valid && out_eop) in_tail = 0;
            if (in_tail) chk(in_ready == 0, "R7", "in_ready during CRC bytes",
                             int'(in_ready), 0);
            if (out_valid && out_ready) begin
                if (got >= exp_n) begin
                    chk(0, en ? "R2" : "R4", "extra output beat", int'(out_data), 0);
                end else begin
                    chk(out_data == exp_d[got],
                        (got >= nsend) ? "R3" : (en ? "R2" : "R4"),
                        "data byte", int'(out_data), int'(exp_d[got]));
                    chk(out_sop == exp_s[got] && out_eop == exp_e[got], "R5",
                        "sop/eop flags", int'({out_sop, out_eop}),
                        int'({exp_s[got], exp_e[got]}));
                    chk(int'(out_err) == exp_r[got], "R9", "error code",
                        int'(out_err), exp_r[got]);
                    got++;
                end
            end
            prev_stall = out_valid && !out_ready;
            pd = out_data; pe = out_eop;
            if (in_valid && in_ready) begin
                sent++;
                if (sent == nsend && en) in_tail = 1;
            end
        end
        if (cyc >= 3000) chk(0, "R6", "packet timed out", got, exp_n);
        in_valid = 0; in_sop = 0; in_eop = 0; out_ready = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(out_valid == 0, en ? "R2" : "R4", "beat after end",
                int'(out_valid), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7251));
        rst_n = 0; in_valid = 0; in_data = 0; in_sop = 0; in_eop = 0;
        crc_en = 1; poly_sel = 0; blk_len = 8; out_ready = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);

        run_pkt(8,  1, 0, 5,  1, 1, 0, 0);  // R2 R3 plain, poly A
        run_pkt(6,  0, 0, 6,  1, 1, 0, 0);  // R4 bypass
        run_pkt(20, 1, 1, 17, 1, 1, 1, 1);  // R3 poly B, R6 gaps, R8 stalls
        run_pkt(20, 1, 0, 5,  1, 1, 0, 1);  // R9 early end -> 11
        run_pkt(10, 1, 1, 7,  1, 0, 1, 0);  // R9 missing end -> 10
        run_pkt(9,  1, 0, 6,  0, 1, 0, 1);  // R9 missing start -> 01
        run_pkt(12, 0, 0, 4,  0, 1, 1, 1);  // R9 bypass early end beats missing start
        run_pkt(4,  1, 1, 1,  1, 1, 0, 1);  // R2 single payload byte
        run_pkt(1,  0, 0, 1,  1, 1, 0, 0);  // R4 single byte bypass
        for (int p = 0; p < 40; p++) begin
            int  k  = 4 + int'($urandom % 37);
            bit  en = 1'($urandom);
            run_pkt(k, en, 1'($urandom), en ? k - 3 : k, 1, 1,
                    1'($urandom), 1'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule